// File: doc/BRIEF.md
# Interrupt Acceptance Unit

This unit sits beside a CPU core and decides when an interrupt request is taken. Two sources compete. The first is an external 4-bit priority level, held steady by its source for as long as the request stands. The second is an on-chip peripheral request, posted with a one-cycle strobe, that carries its own level and a 7-bit vector. The unit keeps the status register (SR). Its interrupt mask sits in SR bits 7:4. A request is taken when the winning level is greater than that mask and the core is not in a branch delay slot.

When a request is taken, the unit stalls the core and runs the exception entry over a 32-bit memory port that uses a valid/ready handshake. It first stores the old SR one word below the stack pointer. It then stores the return PC two words below it. After that it raises the mask to the accepted level and reads the handler address from the vector table. At the end it hands the core the new PC and the new stack pointer. The whole entry takes at least a fixed minimum number of cycles, set by a parameter.

The core supplies its PC, stack pointer and vector base as inputs. It may load SR through a write port, but only while no entry is in progress.

Top module: `irq_accept`

## Requirements
- R1: After reset, SR reads 0x000000F0, and `busy`, `ack`, `ctx_load` and `mem_valid` are all low. No internal request is pending.
- R2: A request is taken only when its level is strictly greater than SR[7:4]. A level equal to or below the mask produces no `ack`.
- R3: When both sources are pending, the external level wins only if it is strictly greater than the internal level. On a tie or a lower external level, the internal request is taken.
- R4: The vector number of an external request is 64 + level/2, using integer division. An internal request uses its posted 7-bit vector. The handler address is read from `vbr_in` + 4 × vector.
- R5: The entry performs exactly three bus transfers, in this order: a write of the old SR to SP−4, a write of the PC to SP−8, and a read of the vector address. SP, PC and the vector base are the values present when the request is taken. While `mem_ready` is low, the request holds its address, data and direction.
- R6: After the PC write, SR[7:4] becomes the accepted level and all other SR bits keep their value. During `ctx_load`, `pc_new` equals the word read from the vector table and `sp_new` equals SP−8.
- R7: A taken internal request is cleared automatically. An external request is a level: it is taken again whenever the mask later drops below it.
- R8: While `in_delay_slot` is high, no request is taken. A request that is still pending is taken once the signal drops.
- R9: `busy` stays high for max(MIN_CYCLES, 4 + memory wait cycles) cycles, which is exactly 13 cycles with the default parameter and no wait states. `ctx_load` is high in its last cycle only.
- R10: `ack` is a one-cycle pulse in the first busy cycle. `ack_level` then shows the accepted level and holds it until the next acceptance.
- R11: A write through `sr_we` while idle loads all 32 SR bits and blocks acceptance in that cycle. A write while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_level | input | 4 | External request level, 0 = none |
| int_req | input | 1 | Strobe that posts or replaces the internal request |
| int_level | input | 4 | Level of the posted internal request |
| int_vector | input | 7 | Vector of the posted internal request |
| in_delay_slot | input | 1 | Core is executing a branch delay slot |
| sr_we | input | 1 | SR write enable from the core |
| sr_wdata | input | 32 | SR write data |
| pc_in | input | 32 | Core PC to be saved |
| sp_in | input | 32 | Core stack pointer |
| vbr_in | input | 32 | Vector table base |
| sr | output | 32 | Current status register |
| ack | output | 1 | Acceptance pulse |
| ack_level | output | 4 | Level of the last accepted request |
| busy | output | 1 | Entry in progress, core stalled |
| ctx_load | output | 1 | Core loads `pc_new` and `sp_new` this cycle |
| pc_new | output | 32 | Handler address |
| sp_new | output | 32 | Stack pointer after the two pushes |
| mem_valid | output | 1 | Bus request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Bus address |
| mem_wdata | output | 32 | Bus write data |
| mem_ready | input | 1 | Bus transfer accepted |
| mem_rdata | input | 32 | Bus read data |

## Verification
The bench goes after the boundaries of the level comparisons, which are easy to get off by one:
- Levels equal to the mask, ties between the two sources, and an external level just one above the internal level. A design that used ≥ instead of > would take masked interrupts, or hand a tie to the external source.
- Random bus stalls, which test the cycle count of `busy`. A design that counted stall cycles against the minimum, or ignored them, would release the core at the wrong time.
- The clear of the internal request and the re-arming of the external one. A design that got this wrong would either re-enter the handler for an internal request already served, or lose a level that is still asserted.
- Delay-slot blocking and SR writes made during an entry. A design that let either through would corrupt the mask that was just raised.

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int MIN_CYCLES = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  ext_level,
  input  logic        int_req,
  input  logic [3:0]  int_level,
  input  logic [6:0]  int_vector,
  input  logic        in_delay_slot,
  input  logic        sr_we,
  input  logic [31:0] sr_wdata,
  input  logic [31:0] pc_in,
  input  logic [31:0] sp_in,
  input  logic [31:0] vbr_in,
  output logic [31:0] sr,
  output logic        ack,
  output logic [3:0]  ack_level,
  output logic        busy,
  output logic        ctx_load,
  output logic [31:0] pc_new,
  output logic [31:0] sp_new,
  output logic        mem_valid,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  localparam int CW = $clog2(MIN_CYCLES + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(MIN_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_PSR, S_PPC, S_VEC, S_WAIT, S_LOAD} state_t;
  state_t state;

  logic          pend_int;
  logic [3:0]    pend_lvl;
  logic [6:0]    pend_vec;
  logic [3:0]    lvl_q;
  logic [6:0]    vec_q;
  logic [31:0]   sr_save, pc_save, sp_q, vbr_q;
  logic [CW-1:0] cnt;

  logic [3:0] int_eff, win_lvl;
  logic [6:0] win_vec;
  logic       take_ext, accept;

  assign int_eff  = pend_int ? pend_lvl : 4'd0;
  assign take_ext = ext_level > int_eff;
  assign win_lvl  = take_ext ? ext_level : int_eff;
  assign win_vec  = take_ext ? {4'b1000, ext_level[3:1]} : pend_vec;
  assign accept   = (state == S_IDLE) && !in_delay_slot && !sr_we && (win_lvl > sr[7:4]);

  assign busy      = state != S_IDLE;
  assign ctx_load  = state == S_LOAD;
  assign sp_new    = sp_q - 32'd8;
  assign mem_valid = (state == S_PSR) || (state == S_PPC) || (state == S_VEC);
  assign mem_write = (state == S_PSR) || (state == S_PPC);

  always_comb begin
    mem_addr  = 32'd0;
    mem_wdata = 32'd0;
    case (state)
      S_PSR: begin mem_addr = sp_q - 32'd4; mem_wdata = sr_save; end
      S_PPC: begin mem_addr = sp_q - 32'd8; mem_wdata = pc_save; end
      S_VEC: mem_addr = vbr_q + {23'd0, vec_q, 2'b00};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sr        <= 32'h0000_00F0;
      pend_int  <= 1'b0;
      pend_lvl  <= 4'd0;
      pend_vec  <= 7'd0;
      lvl_q     <= 4'd0;
      vec_q     <= 7'd0;
      sr_save   <= 32'd0;
      pc_save   <= 32'd0;
      sp_q      <= 32'd0;
      vbr_q     <= 32'd0;
      cnt       <= '0;
      ack       <= 1'b0;
      ack_level <= 4'd0;
      pc_new    <= 32'd0;
    end else begin
      ack <= accept;
      if (int_req) begin
        pend_int <= 1'b1;
        pend_lvl <= int_level;
        pend_vec <= int_vector;
      end else if (accept && !take_ext) begin
        pend_int <= 1'b0;
      end
      if (state == S_IDLE && sr_we) sr <= sr_wdata;
      if (busy && cnt < CNT_SAT) cnt <= cnt + 1'b1;
      case (state)
        S_IDLE: if (accept) begin
          state     <= S_PSR;
          lvl_q     <= win_lvl;
          vec_q     <= win_vec;
          ack_level <= win_lvl;
          sr_save   <= sr;
          pc_save   <= pc_in;
          sp_q      <= sp_in;
          vbr_q     <= vbr_in;
          cnt       <= CW'(1);
        end
        S_PSR: if (mem_ready) state <= S_PPC;
        S_PPC: if (mem_ready) begin
          state   <= S_VEC;
          sr[7:4] <= lvl_q;
        end
        S_VEC: if (mem_ready) begin
          pc_new <= mem_rdata;
          state  <= (cnt >= CNT_LAST) ? S_LOAD : S_WAIT;
        end
        S_WAIT: if (cnt >= CNT_LAST) state <= S_LOAD;
        S_LOAD: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int MIN_CYCLES = 13
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_delay_slot,
  input logic [31:0] sr,
  input logic        ack,
  input logic [3:0]  ack_level,
  input logic        busy,
  input logic        ctx_load,
  input logic        mem_valid,
  input logic        mem_write,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 0;
    else run <= busy ? ((run < MIN_CYCLES) ? run + 1 : run) : 0;
  end

  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  a_r10_ack_opens_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (busy && !$past(busy)));
  a_r2_level_over_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ack_level > sr[7:4]));
  a_r8_delay_slot_block: assert property (@(posedge clk) disable iff (!rst_n)
    (in_delay_slot && !busy) |=> !ack);
  a_r5_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));
  a_r6_mask_at_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> (sr[7:4] == ack_level));
  a_r9_min_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |-> (run >= MIN_CYCLES - 1));
  a_r9_load_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> !busy);
endmodule

bind irq_accept irq_accept_chk #(.MIN_CYCLES(MIN_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_delay_slot(in_delay_slot), .sr(sr),
  .ack(ack), .ack_level(ack_level), .busy(busy), .ctx_load(ctx_load),
  .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/sim_irq_accept.sv
module sim_irq_accept;
  localparam int MINC = 13;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  ext_level = 0, int_level = 0;
  logic        int_req = 0, in_delay_slot = 0, sr_we = 0;
  logic [6:0]  int_vector = 0;
  logic [31:0] sr_wdata = 0, pc_in = 0, sp_in = 0, vbr_in = 0;
  logic [31:0] sr, pc_new, sp_new, mem_addr, mem_wdata, mem_rdata;
  logic        ack, busy, ctx_load, mem_valid, mem_write;
  logic        mem_ready = 1;
  logic [3:0]  ack_level;

  int checks = 0, errors = 0, stall_pct = 0;
  int log_n = 0, waits = 0, busy_cnt = 0;
  logic [31:0] log_addr [0:7];
  logic [31:0] log_data [0:7];
  logic        log_wr   [0:7];

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return (a * 32'd3) ^ 32'h5A5A_1234;
  endfunction
  assign mem_rdata = rd_fn(mem_addr);

  irq_accept #(.MIN_CYCLES(MINC)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_level(ext_level), .int_req(int_req),
    .int_level(int_level), .int_vector(int_vector), .in_delay_slot(in_delay_slot),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .pc_in(pc_in), .sp_in(sp_in), .vbr_in(vbr_in),
    .sr(sr), .ack(ack), .ack_level(ack_level), .busy(busy), .ctx_load(ctx_load),
    .pc_new(pc_new), .sp_new(sp_new), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    mem_ready = (($urandom % 100) >= stall_pct);
    if (busy) busy_cnt++;
    if (mem_valid && !mem_ready) waits++;
    if (mem_valid && mem_ready && log_n < 8) begin
      log_addr[log_n] = mem_addr;
      log_data[log_n] = mem_wdata;
      log_wr[log_n]   = mem_write;
      log_n++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_sr(input logic [31:0] v);
    @(negedge clk); sr_we = 1; sr_wdata = v;
    @(negedge clk); sr_we = 0;
    chk(sr == v, "R11", "sr after write", sr, v);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic run_case(input logic [3:0] e, input logic [3:0] il, input logic [6:0] iv,
                          input logic [31:0] srv, input logic ds, input int stall,
                          input logic poke, input logic [31:0] pcv, input logic [31:0] spv,
                          input logic [31:0] vbv);
    logic        take_ext, acc;
    logic [3:0]  lvl;
    logic [6:0]  vec;
    logic [31:0] exp_sr;
    int          exp_busy;
    bit          seen;
    take_ext = e > il;
    lvl = take_ext ? e : il;
    vec = take_ext ? 7'(64 + e / 2) : iv;
    acc = lvl > srv[7:4];
    @(negedge clk);
    ext_level = 0; sr_we = 1; sr_wdata = srv; int_req = 1; int_level = il; int_vector = iv;
    in_delay_slot = 0; stall_pct = stall;
    @(negedge clk);
    sr_we = 0; int_req = 0;
    chk(sr == srv, "R11", "sr loaded while idle", sr, srv);
    ext_level = e; in_delay_slot = ds; pc_in = pcv; sp_in = spv; vbr_in = vbv;
    log_n = 0; waits = 0; busy_cnt = 0;
    @(negedge clk);
    if (!acc || ds) begin
      seen = 0;
      for (int i = 0; i < 3; i++) begin
        if (ack || busy) seen = 1;
        @(negedge clk);
      end
      if (!acc) begin
        chk(!seen, "R2", "masked request taken", 32'(seen), 0);
        return;
      end
      chk(!seen, "R8", "taken in delay slot", 32'(seen), 0);
      in_delay_slot = 0;
      @(negedge clk);
    end
    chk(ack == 1, "R10", "ack pulse", 32'(ack), 1);
    chk(ack_level == lvl, "R3", "accepted level", 32'(ack_level), 32'(lvl));
    @(negedge clk);
    chk(ack == 0, "R10", "ack single cycle", 32'(ack), 0);
    if (poke) begin
      sr_we = 1; sr_wdata = 32'h0;
      @(negedge clk); sr_we = 0;
    end
    for (int i = 0; i < 400 && !ctx_load; i++) @(negedge clk);
    exp_sr = (srv & ~32'hF0) | {24'd0, lvl, 4'd0};
    chk(ctx_load == 1, "R9", "ctx_load seen", 32'(ctx_load), 1);
    chk(sr == exp_sr, "R6", "sr after entry", sr, exp_sr);
    chk(sp_new == spv - 8, "R6", "sp_new", sp_new, spv - 8);
    chk(pc_new == rd_fn(vbv + 32'(vec) * 4), "R6", "pc_new", pc_new, rd_fn(vbv + 32'(vec) * 4));
    @(negedge clk);
    chk(busy == 0 && ctx_load == 0, "R9", "idle after load", 32'({busy, ctx_load}), 0);
    exp_busy = (4 + waits > MINC) ? 4 + waits : MINC;
    chk(busy_cnt == exp_busy, "R9", "busy length", busy_cnt, exp_busy);
    chk(log_n == 3, "R5", "transfer count", log_n, 3);
    chk(log_wr[0] && log_addr[0] == spv - 4 && log_data[0] == srv, "R5", "SR push",
        log_addr[0], spv - 4);
    chk(log_wr[1] && log_addr[1] == spv - 8 && log_data[1] == pcv, "R5", "PC push",
        log_data[1], pcv);
    chk(!log_wr[2] && log_addr[2] == vbv + 32'(vec) * 4, "R4", "vector fetch address",
        log_addr[2], vbv + 32'(vec) * 4);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(sr == 32'hF0, "R1", "reset sr", sr, 32'hF0);
    chk(!busy && !ack && !ctx_load && !mem_valid, "R1", "reset outputs",
        32'({busy, ack, ctx_load, mem_valid}), 0);
    rst_n = 1;
    set_sr(32'h0);
    repeat (3) @(negedge clk);
    chk(!ack && !busy, "R1", "no pending after reset", 32'({ack, busy}), 0);

    run_case(4'd5, 4'd5, 7'd20, 32'h0000_0020, 0, 0, 0, 32'h1000, 32'h8000, 32'h0);
    run_case(4'd6, 4'd5, 7'd21, 32'h0000_0020, 0, 0, 0, 32'h2000, 32'h9000, 32'h400);
    run_case(4'd1, 4'd0, 7'd0,  32'h0000_0000, 0, 0, 0, 32'h3000, 32'hA000, 32'h0);
    run_case(4'd15, 4'd0, 7'd0, 32'h0000_00E0, 0, 0, 0, 32'h3004, 32'hA010, 32'h100);
    run_case(4'd7, 4'd0, 7'd0,  32'h0000_0070, 0, 0, 0, 32'h3008, 32'hA020, 32'h100);
    run_case(4'd0, 4'd9, 7'd99, 32'h0000_0080, 0, 0, 0, 32'h300C, 32'hA030, 32'h100);
    run_case(4'd8, 4'd3, 7'd5,  32'hABCD_0312, 1, 0, 1, 32'h4000, 32'hB000, 32'h200);
    run_case(4'd4, 4'd2, 7'd1,  32'h0000_0010, 0, 60, 0, 32'h5000, 32'hC000, 32'h0);

    run_case(4'd0, 4'd9, 7'd40, 32'h0000_0010, 0, 0, 0, 32'h6000, 32'hD000, 32'h0);
    set_sr(32'h0);
    repeat (3) @(negedge clk);
    chk(!ack && !busy, "R7", "internal cleared after accept", 32'({ack, busy}), 0);

    run_case(4'd6, 4'd0, 7'd0,  32'h0000_0030, 0, 0, 0, 32'h7000, 32'hE000, 32'h0);
    set_sr(32'h0000_0020);
    @(negedge clk);
    chk(ack == 1 && ack_level == 4'd6, "R7", "external level re-taken",
        32'({ack, ack_level}), 32'h16);
    wait_idle();

    for (int n = 0; n < 150; n++) begin
      run_case(4'($urandom), 4'($urandom), 7'($urandom), $urandom,
               ($urandom % 8) == 0, (($urandom % 2) == 0) ? 0 : 40, ($urandom % 6) == 0,
               $urandom & ~32'h3, $urandom & ~32'h3, $urandom & ~32'h3);
    end
    ext_level = 0;
    repeat (4) @(negedge clk);
    summary();
  end
endmodule